// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. On every clock edge where the execute strobe is high, it combines the current accumulator with a second operand and registers the result. It also updates a four-bit flag register holding carry, zero, sign and parity. The second operand comes from a register value or an immediate, chosen by a select input. It supports add and subtract, each with or without carry or borrow, the three bitwise logic operations, compare, register increment and decrement, accumulator complement and carry complement.

A condition output reads the registered flags combinationally. It answers one of eight flag tests chosen by a 3-bit code, which the sequencer uses to decide conditional jumps, calls and returns. The block does not hold the accumulator itself. The surrounding datapath presents the accumulator on `acc_in` and writes `result_q` back to it, or, for increment and decrement, to the register that supplied the operand.

Top module: `accalu`

## Requirements
- R1: Opcodes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) compute acc_in with the operand, plus or minus the stored carry for codes 1 and 3. They set all four flags from the 8-bit result. The operand is imm_val when src_imm is 1 and reg_val otherwise.
- R2: Opcodes 4 (AND), 5 (OR) and 6 (XOR) apply the bitwise function to acc_in and the operand. They clear carry and set zero, sign and parity from the result.
- R3: Opcode 7 (compare) sets the four flags exactly as subtract would, but result_q takes the value of acc_in.
- R4: Opcode 10 loads the bitwise inverse of acc_in with the flags unchanged. Opcode 11 inverts only the carry flag and loads acc_in into result_q.
- R5: Opcodes 8 (increment) and 9 (decrement) add or subtract one from the selected operand. They update zero, sign and parity and leave carry unchanged.
- R6: For subtract, subtract with borrow and compare, carry is a borrow. It is 1 when the operand, plus the incoming borrow for code 3, is larger as an unsigned number than acc_in. For add, carry is the carry out of bit 7.
- R7: The flag bits are: bit 0 carry, bit 1 zero (result equals 0), bit 2 sign (result bit 7), and bit 3 parity. Parity is 1 when the result has an even number of 1 bits.
- R8: cond_true is a combinational function of the flags. The cond_sel codes are 0 not-zero, 1 zero, 2 no-carry, 3 carry, 4 parity-odd, 5 parity-even, 6 positive (sign 0) and 7 minus (sign 1).
- R9: result_q and flags_q change only on a clock edge with exec_en high. With exec_en low they hold, whatever the other inputs do. Reset clears both to zero.
- R10: Opcodes 12 to 15 are no-operations. They load acc_in into result_q and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Execute strobe; the operation takes effect on this edge |
| op_code | input | 4 | Operation select |
| src_imm | input | 1 | 1 selects imm_val as operand, 0 selects reg_val |
| reg_val | input | 8 | Register operand |
| imm_val | input | 8 | Immediate operand |
| acc_in | input | 8 | Current accumulator value |
| cond_sel | input | 3 | Condition code for cond_true |
| result_q | output | 8 | Registered result |
| flags_q | output | 4 | Registered flags {parity, sign, zero, carry} |
| cond_true | output | 1 | Selected condition holds on the current flags |

## Verification
result_q and flags_q are due on the first rising edge after the strobe is presented. The bench drives inputs on the falling edge and compares on the next falling edge, which is half a period after the one register stage. cond_true has no register of its own, so the bench changes cond_sel on a falling edge and samples one nanosecond later, while flags_q is stable. For cycles with the strobe low, the bench drives random inputs and checks on the next falling edge that both registered outputs still hold their previous values.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_CMP = 4'd7,
      OP_INC = 4'd8,
      OP_DEC = 4'd9,
      OP_CPL = 4'd10,
      OP_CMC = 4'd11,
      OP_N12 = 4'd12,
      OP_N13 = 4'd13,
      OP_N14 = 4'd14,
      OP_N15 = 4'd15
   } op_e;

   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_S = 2;
   localparam int FLG_P = 3;
   localparam int NFLAGS = 4;

   typedef enum logic [2:0] {
      CC_NZ = 3'd0,
      CC_Z  = 3'd1,
      CC_NC = 3'd2,
      CC_C  = 3'd3,
      CC_PO = 3'd4,
      CC_PE = 3'd5,
      CC_P  = 3'd6,
      CC_M  = 3'd7
   } cc_e;
endpackage

// File: rtl/accalu_addsub.sv
module accalu_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W-1:0] b_eff;
   logic         c0;
   logic         raw_c;

   assign b_eff = sub ? ~b : b;
   assign c0    = sub ? ~cin : cin;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = c0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
            assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
         end
         assign raw_c = c[W];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
         assign sum   = wide[W-1:0];
         assign raw_c = wide[W];
      end
   endgenerate

   assign cout = sub ? ~raw_c : raw_c;
endmodule

// File: rtl/accalu_logic.sv
module accalu_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   fn,
   output logic [W-1:0] y
);
   always_comb begin
      case (fn)
         2'd0:    y = a & b;
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/accalu_cond.sv
module accalu_cond
   import accalu_pkg::*;
(
   input  logic [NFLAGS-1:0] flags,
   input  logic [2:0]        sel,
   output logic              hit
);
   logic base;

   always_comb begin
      case (sel[2:1])
         2'd0:    base = flags[FLG_Z];
         2'd1:    base = flags[FLG_C];
         2'd2:    base = flags[FLG_P];
         default: base = flags[FLG_S];
      endcase
   end

   // even codes test the flag clear, odd codes test it set
   assign hit = sel[0] ? base : ~base;
endmodule

// File: rtl/accalu.sv
module accalu
   import accalu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  exec_en,
   input  logic [3:0]            op_code,
   input  logic                  src_imm,
   input  logic [W-1:0]          reg_val,
   input  logic [W-1:0]          imm_val,
   input  logic [W-1:0]          acc_in,
   input  logic [2:0]            cond_sel,
   output logic [W-1:0]          result_q,
   output logic [NFLAGS-1:0]     flags_q,
   output logic                  cond_true
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("accalu: W must be at least 2");
      end
   endgenerate

   op_e          op;
   logic [W-1:0] opnd;
   logic [W-1:0] a_in;
   logic [W-1:0] b_in;
   logic         cin;
   logic         sub;
   logic [W-1:0] as_sum;
   logic         as_c;
   logic [W-1:0] lg_y;
   logic [W-1:0] nxt_res;
   logic [NFLAGS-1:0] nxt_flg;

   assign op   = op_e'(op_code);
   assign opnd = src_imm ? imm_val : reg_val;

   always_comb begin
      a_in = acc_in;
      b_in = opnd;
      cin  = 1'b0;
      sub  = 1'b0;
      case (op)
         OP_ADC:         cin = flags_q[FLG_C];
         OP_SUB, OP_CMP: sub = 1'b1;
         OP_SBB: begin
            sub = 1'b1;
            cin = flags_q[FLG_C];
         end
         OP_INC: begin
            a_in = opnd;
            b_in = '0;
            cin  = 1'b1;
         end
         OP_DEC: begin
            a_in = opnd;
            b_in = '0;
            cin  = 1'b1;
            sub  = 1'b1;
         end
         default: ;
      endcase
   end

   accalu_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
      .a    (a_in),
      .b    (b_in),
      .cin  (cin),
      .sub  (sub),
      .sum  (as_sum),
      .cout (as_c)
   );

   accalu_logic #(.W(W)) u_logic (
      .a  (acc_in),
      .b  (opnd),
      .fn (op_code[1:0]),
      .y  (lg_y)
   );

   always_comb begin
      nxt_res = acc_in;
      nxt_flg = flags_q;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            nxt_res        = as_sum;
            nxt_flg[FLG_C] = as_c;
            nxt_flg[FLG_Z] = (as_sum == '0);
            nxt_flg[FLG_S] = as_sum[MSB];
            nxt_flg[FLG_P] = ~^as_sum;
         end
         OP_CMP: begin
            nxt_flg[FLG_C] = as_c;
            nxt_flg[FLG_Z] = (as_sum == '0);
            nxt_flg[FLG_S] = as_sum[MSB];
            nxt_flg[FLG_P] = ~^as_sum;
         end
         OP_AND, OP_OR, OP_XOR: begin
            nxt_res        = lg_y;
            nxt_flg[FLG_C] = 1'b0;
            nxt_flg[FLG_Z] = (lg_y == '0);
            nxt_flg[FLG_S] = lg_y[MSB];
            nxt_flg[FLG_P] = ~^lg_y;
         end
         OP_INC, OP_DEC: begin
            nxt_res        = as_sum;
            nxt_flg[FLG_Z] = (as_sum == '0);
            nxt_flg[FLG_S] = as_sum[MSB];
            nxt_flg[FLG_P] = ~^as_sum;
         end
         OP_CPL: nxt_res = ~acc_in;
         OP_CMC: nxt_flg[FLG_C] = ~flags_q[FLG_C];
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         flags_q  <= '0;
      end else if (exec_en) begin
         result_q <= nxt_res;
         flags_q  <= nxt_flg;
      end
   end

   accalu_cond u_cond (
      .flags (flags_q),
      .sel   (cond_sel),
      .hit   (cond_true)
   );
endmodule

// File: rtl/accalu_chk.sv
module accalu_chk
   import accalu_pkg::*;
#(
   parameter int W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_en,
   input logic [3:0]        op_code,
   input logic [W-1:0]      acc_in,
   input logic [W-1:0]      result_q,
   input logic [NFLAGS-1:0] flags_q
);
   logic is_logic;
   logic is_incdec;
   logic writes_zsp;

   assign is_logic   = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
   assign is_incdec  = (op_code == OP_INC) || (op_code == OP_DEC);
   assign writes_zsp = is_logic || is_incdec || (op_code <= OP_SBB);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(result_q) && $stable(flags_q)); // R9

   AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op_code == OP_CMP) |=> result_q == $past(acc_in)); // R3

   AST_LOGIC_CLEARS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && is_logic) |=> !flags_q[FLG_C]); // R2

   AST_INCDEC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && is_incdec) |=> flags_q[FLG_C] == $past(flags_q[FLG_C])); // R5

   AST_CMC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op_code == OP_CMC) |=> (flags_q[FLG_C] != $past(flags_q[FLG_C]))
         && (flags_q[NFLAGS-1:1] == $past(flags_q[NFLAGS-1:1]))); // R4

   AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && writes_zsp) |=> flags_q[FLG_P] == ~^result_q); // R7

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && writes_zsp) |=> flags_q[FLG_Z] == (result_q == '0)); // R7

   AST_NOP_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op_code >= OP_N12) |=> $stable(flags_q)); // R10
endmodule

bind accalu accalu_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .exec_en  (exec_en),
   .op_code  (op_code),
   .acc_in   (acc_in),
   .result_q (result_q),
   .flags_q  (flags_q)
);

// File: tb/accalu_tb.sv
`timescale 1ns/1ps
module accalu_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec_en = 1'b0;
   logic [3:0] op_code = '0;
   logic       src_imm = 1'b0;
   logic [7:0] reg_val = '0;
   logic [7:0] imm_val = '0;
   logic [7:0] acc_in = '0;
   logic [2:0] cond_sel = '0;
   logic [7:0] result_q;
   logic [3:0] flags_q;
   logic       cond_true;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   int  cyc = 0;
   logic [3:0] exp_f = '0;
   logic [7:0] exp_r = '0;

   always #5 clk = ~clk;

   accalu u_dut (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
      .src_imm(src_imm), .reg_val(reg_val), .imm_val(imm_val), .acc_in(acc_in),
      .cond_sel(cond_sel), .result_q(result_q), .flags_q(flags_q), .cond_true(cond_true)
   );

   function automatic string rtag(input logic [3:0] op);
      if (op <= 4'd3)  return "R1/R6";
      if (op <= 4'd6)  return "R2";
      if (op == 4'd7)  return "R3/R6";
      if (op <= 4'd9)  return "R5";
      if (op <= 4'd11) return "R4";
      return "R10";
   endfunction

   // returns {flags, result}
   function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [3:0] f);
      int s;
      logic [7:0] r;
      logic [3:0] nf;
      bit zsp;
      nf = f; r = a; zsp = 1'b0;
      case (op)
         4'd0, 4'd1: begin
            s = int'(a) + int'(b) + ((op == 4'd1) ? int'(f[0]) : 0);
            r = s[7:0]; nf[0] = (s > 255); zsp = 1'b1;
         end
         4'd2, 4'd3, 4'd7: begin
            s = int'(a) - int'(b) - ((op == 4'd3) ? int'(f[0]) : 0);
            r = s[7:0]; nf[0] = (s < 0); zsp = 1'b1;
         end
         4'd4: begin r = a & b; nf[0] = 1'b0; zsp = 1'b1; end
         4'd5: begin r = a | b; nf[0] = 1'b0; zsp = 1'b1; end
         4'd6: begin r = a ^ b; nf[0] = 1'b0; zsp = 1'b1; end
         4'd8: begin r = b + 8'd1; zsp = 1'b1; end
         4'd9: begin r = b - 8'd1; zsp = 1'b1; end
         4'd10: r = ~a;
         4'd11: nf[0] = ~f[0];
         default: ;
      endcase
      if (zsp) begin
         nf[1] = (r == 8'd0);
         nf[2] = r[7];
         nf[3] = ~^r;
      end
      if (op == 4'd7) r = a;
      return {nf, r};
   endfunction

   function automatic bit cond_model(input logic [2:0] sel, input logic [3:0] f);
      case (sel)
         3'd0: return !f[1];
         3'd1: return f[1];
         3'd2: return !f[0];
         3'd3: return f[0];
         3'd4: return !f[3];
         3'd5: return f[3];
         3'd6: return !f[2];
         default: return f[2];
      endcase
   endfunction

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got flags=%h res=%h, expected flags=%h res=%h",
                  tag, act[11:8], act[7:0], exp[11:8], exp[7:0]);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] rv,
                        input logic [7:0] iv, input logic imm);
      logic [11:0] e;
      @(negedge clk);
      exec_en = 1'b1; op_code = op; acc_in = a; reg_val = rv; imm_val = iv; src_imm = imm;
      e = model(op, a, imm ? iv : rv, exp_f);
      @(negedge clk);
      exec_en = 1'b0;
      exp_f = e[11:8]; exp_r = e[7:0];
      chk(rtag(op), {flags_q, result_q}, e);
   endtask

   task automatic idle_check();
      @(negedge clk);
      exec_en = 1'b0; op_code = 4'($urandom); acc_in = 8'($urandom);
      reg_val = 8'($urandom); imm_val = 8'($urandom); src_imm = 1'($urandom);
      @(negedge clk);
      chk("R9 idle hold", {flags_q, result_q}, {exp_f, exp_r});
   endtask

   task automatic cond_sweep();
      for (int s = 0; s < 8; s++) begin
         cond_sel = 3'(s);
         #1;
         chk("R8 cond", {11'd0, cond_true}, {11'd0, cond_model(3'(s), exp_f)});
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got cycles=%0d, expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk("R9 reset", {flags_q, result_q}, 12'h000);
      rst_n = 1'b1;

      // R1/R6: add overflow to zero, sets carry, zero and parity
      apply(4'd0, 8'hFF, 8'h01, 8'h00, 1'b0);
      chk("R7 flags after FF+01", {8'd0, flags_q}, {8'd0, 4'b1011});
      apply(4'd1, 8'h10, 8'h00, 8'h05, 1'b1); // R1 adc uses carry and immediate
      apply(4'd2, 8'h10, 8'h20, 8'h00, 1'b0); // R6 borrow
      apply(4'd3, 8'h05, 8'h04, 8'h00, 1'b0); // R6 sbb with borrow in -> 0
      apply(4'd7, 8'h42, 8'h42, 8'h00, 1'b0); // R3 equal
      apply(4'd7, 8'h01, 8'h00, 8'h80, 1'b1); // R3 borrow, acc kept
      apply(4'd11, 8'h33, 8'h00, 8'h00, 1'b0); // R4 cmc
      apply(4'd11, 8'h33, 8'h00, 8'h00, 1'b0); // R4 cmc back
      apply(4'd0, 8'hF0, 8'h20, 8'h00, 1'b0); // set carry
      apply(4'd4, 8'hF0, 8'h0F, 8'h00, 1'b0); // R2 and clears carry
      apply(4'd0, 8'hF0, 8'h20, 8'h00, 1'b0);
      apply(4'd8, 8'h00, 8'hFF, 8'h00, 1'b0); // R5 inc wraps, carry held
      apply(4'd9, 8'h00, 8'h00, 8'h00, 1'b0); // R5 dec wraps
      apply(4'd10, 8'h5A, 8'h00, 8'h00, 1'b0); // R4 cpl
      apply(4'd13, 8'h77, 8'h11, 8'h22, 1'b1); // R10 no-op
      cond_sweep();
      idle_check();

      for (int i = 0; i < 600; i++) begin
         apply(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
         if (i % 8 == 0) cond_sweep();
         if (i % 16 == 3) idle_check();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule